// File: doc/BRIEF.md
# Program Store Self-Programming Controller

This block gives a CPU read and write access to its own 1K-word, 14-bit program store, which is held here as a register array inside the block. Software works through six byte-wide registers. Two registers hold the word address, two hold the data word, one is a control register, and one is a key port that has no storage behind it. A read of the array follows a fixed pipeline: the instruction slot in the second cycle after the read starts is thrown away, and the fetched word shows up in the data registers on the cycle after that slot.

Writes are guarded in three ways. A power-up lockout timer must have expired. The write-enable bit must already be set. The key bytes 55h and AAh must have reached the key port just before the write command. Each accepted write drops the current data word into one slot of a four-word staging buffer. When the slot index is 3, the whole aligned group is committed to the array and the CPU is held by a stall output for a programmable number of cycles. A commit to the first group of a 16-word row erases that row first. Commits to the other three groups of the row only program their four words.

Top module: `pgm_store_ctrl`

## Requirements
- R1: Register selects are 0 address-low, 1 address-high, 2 data-low, 3 data-high, 4 control, 5 key. The 10-bit address is {addr-high[1:0], addr-low}. The 14-bit word is {data-high[5:0], data-low}. Address-high and data-high read back zeros above their implemented bits.
- R2: Control bit 0 starts a read and bit 1 starts a write. Software can set these bits but not clear them: writing 0 to them has no effect. Hardware clears each one when its operation ends.
- R3: Control bit 2 is the write enable and reads 0 after reset. A write command is accepted only if this bit was already 1 before the command.
- R4: A write command is accepted only if the two register writes just before it were 55h and then AAh to the key port. The key port always reads 00h.
- R5: Suppose a read is started by the control write captured at edge E0. During the cycle that ends at edge E2, `slot_discard` is 1. The addressed word is in the data registers from E2 onward, and the read bit then reads 0.
- R6: The data registers keep a fetched word until the next array read completes or software writes them.
- R7: An accepted write with address bits [1:0] not equal to 3 stores the data word in that buffer slot and finishes at once. It raises no stall, and the write bit reads 0 afterwards.
- R8: An accepted write with address bits [1:0] equal to 3 holds `cpu_stall` high for PROG_CYCLES cycles. It then writes all four buffer words to the aligned group.
- R9: Until LOCKOUT_CYCLES cycles have passed since reset, write commands are refused and do not change the array.
- R10: Array words read 3FFFh after reset. A commit to a group whose address bits [3:2] are 0 first sets all 16 words of that row to 3FFFh. Commits to the other groups leave the rest of the row untouched.
- R11: A wrong key byte, or a write to any other register, returns the key sequence to its start.
- R12: Register writes are ignored during the discarded read slot and while `cpu_stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (see R1) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_stall | output | 1 | Holds the CPU during erase/program |
| slot_discard | output | 1 | Marks the instruction slot consumed by an array read |

## Verification
The assertions check, on every cycle, the conditions for a stall to begin. A stall may only start from a control write to slot 3 that had the key armed, the write enable set and the lockout expired. The assertions also check that the discard slot follows a pending read, that writes landing in that slot do not change the address, and that the key only arms right after AAh. The array contents can only be shown by the bench scenarios. Those scenarios cover the erase that happens on the first group of a row but not on the later groups, refused writes that leave 3FFFh in place, the exact cycles of the read pipeline, and the stall length.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
    typedef enum logic [2:0] {
        SEL_ADR_LO = 3'd0,
        SEL_ADR_HI = 3'd1,
        SEL_DAT_LO = 3'd2,
        SEL_DAT_HI = 3'd3,
        SEL_CTRL   = 3'd4,
        SEL_KEY    = 3'd5
    } reg_sel_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int CTRL_RD_BIT   = 0;
    localparam int CTRL_WR_BIT   = 1;
    localparam int CTRL_WREN_BIT = 2;
endpackage

// File: rtl/pgm_unlock.sv
module pgm_unlock
    import pgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic       other_we,
    input  logic [7:0] wdata,
    output logic       armed
);
    typedef enum logic [1:0] {U_IDLE, U_HALF, U_ARMED} ustate_e;
    ustate_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (other_we) begin
            st_d = U_IDLE;
        end else if (key_we) begin
            if (wdata == KEY_FIRST)                          st_d = U_HALF;
            else if (wdata == KEY_SECOND && st_q == U_HALF)  st_d = U_ARMED;
            else                                             st_d = U_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= U_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == U_ARMED);

    // R4: arming only directly after the second key byte
    p_arm_after_second_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_we && wdata == KEY_SECOND));
    // R11: any other register write disarms
    p_other_write_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        other_we |=> !armed);
endmodule

// File: rtl/pgm_array.sv
module pgm_array #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 14,
    parameter int GROUP_W = 2,
    parameter int ROW_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic                              erase_row,
    input  logic [ADDR_W-GROUP_W-1:0]         grp,
    input  logic [(1<<GROUP_W)*DATA_W-1:0]    words,
    input  logic [ADDR_W-1:0]                 raddr,
    output logic [DATA_W-1:0]                 rdata
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int GROUPS_N = 1 << GROUP_W;
    localparam int ROW_N    = 1 << ROW_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (commit) begin
            if (erase_row) begin
                for (int j = 0; j < ROW_N; j++)
                    mem_q[{grp[ADDR_W-GROUP_W-1:ROW_W-GROUP_W], ROW_W'(j)}] <= '1;
            end
            for (int k = 0; k < GROUPS_N; k++)
                mem_q[{grp, GROUP_W'(k)}] <= words[k*DATA_W +: DATA_W];
        end
    end

    assign rdata = mem_q[raddr];

    // R8: a commit is a single-cycle event
    p_commit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/pgm_store_ctrl.sv
module pgm_store_ctrl
    import pgm_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int DATA_W         = 14,
    parameter int GROUP_WORDS    = 4,
    parameter int ROW_WORDS      = 16,
    parameter int PROG_CYCLES    = 8,
    parameter int LOCKOUT_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       cpu_stall,
    output logic       slot_discard
);
    localparam int GROUP_W  = $clog2(GROUP_WORDS);
    localparam int ROW_W    = $clog2(ROW_WORDS);
    localparam int CNT_W    = $clog2(PROG_CYCLES + 1);
    localparam int LOCK_W   = $clog2(LOCKOUT_CYCLES + 1);
    localparam int HI_ADR_W = ADDR_W - 8;
    localparam int HI_DAT_W = DATA_W - 8;

    typedef struct packed {
        logic [ADDR_W-1:0]                   addr;
        logic [DATA_W-1:0]                   data;
        logic                                wren;
        logic                                rd_pend;
        logic                                rd_slot;
        logic                                busy;
        logic [CNT_W-1:0]                    cnt;
        logic [LOCK_W-1:0]                   lock_cnt;
        logic [GROUP_WORDS-1:0][DATA_W-1:0]  stage;
    } state_t;

    state_t s_d, s_q;

    logic              armed;
    logic              lock_done;
    logic              accept;
    logic              key_we;
    logic              other_we;
    logic              commit;
    logic              wr_go;
    logic [DATA_W-1:0] arr_rdata;
    logic [GROUP_W-1:0] slot;

    assign lock_done = (s_q.lock_cnt == LOCK_W'(LOCKOUT_CYCLES));
    assign accept    = reg_we && !s_q.busy && !s_q.rd_slot;
    assign key_we    = accept && (reg_sel == SEL_KEY);
    assign other_we  = accept && (reg_sel != SEL_KEY);
    assign commit    = s_q.busy && (s_q.cnt == CNT_W'(1));
    assign slot      = s_q.addr[GROUP_W-1:0];
    assign wr_go     = other_we && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_WR_BIT]
                       && armed && s_q.wren && lock_done;

    pgm_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (key_we),
        .other_we (other_we),
        .wdata    (reg_wdata),
        .armed    (armed)
    );

    pgm_array #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .GROUP_W (GROUP_W),
        .ROW_W   (ROW_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .erase_row (s_q.addr[ROW_W-1:GROUP_W] == '0),
        .grp       (s_q.addr[ADDR_W-1:GROUP_W]),
        .words     (s_q.stage),
        .raddr     (s_q.addr),
        .rdata     (arr_rdata)
    );

    always_comb begin
        s_d = s_q;
        if (!lock_done) s_d.lock_cnt = s_q.lock_cnt + 1'b1;

        // read pipeline: pending cycle, then discarded slot that fetches
        if (s_q.rd_slot) begin
            s_d.data    = arr_rdata;
            s_d.rd_slot = 1'b0;
        end else if (s_q.rd_pend) begin
            s_d.rd_pend = 1'b0;
            s_d.rd_slot = 1'b1;
        end

        // erase/program timer
        if (s_q.busy) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (commit) s_d.busy = 1'b0;
        end

        if (other_we) begin
            case (reg_sel)
                SEL_ADR_LO: s_d.addr[7:0]        = reg_wdata;
                SEL_ADR_HI: s_d.addr[ADDR_W-1:8] = reg_wdata[HI_ADR_W-1:0];
                SEL_DAT_LO: s_d.data[7:0]        = reg_wdata;
                SEL_DAT_HI: s_d.data[DATA_W-1:8] = reg_wdata[HI_DAT_W-1:0];
                SEL_CTRL: begin
                    s_d.wren = reg_wdata[CTRL_WREN_BIT];
                    if (reg_wdata[CTRL_RD_BIT] && !s_q.rd_pend) s_d.rd_pend = 1'b1;
                    if (wr_go) begin
                        s_d.stage[slot] = s_q.data;
                        if (&slot) begin
                            s_d.busy = 1'b1;
                            s_d.cnt  = CNT_W'(PROG_CYCLES);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_ADR_LO: reg_rdata = s_q.addr[7:0];
            SEL_ADR_HI: reg_rdata = {{(8-HI_ADR_W){1'b0}}, s_q.addr[ADDR_W-1:8]};
            SEL_DAT_LO: reg_rdata = s_q.data[7:0];
            SEL_DAT_HI: reg_rdata = {{(8-HI_DAT_W){1'b0}}, s_q.data[DATA_W-1:8]};
            SEL_CTRL:   reg_rdata = {5'b0, s_q.wren, s_q.busy, s_q.rd_pend | s_q.rd_slot};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign cpu_stall    = s_q.busy;
    assign slot_discard = s_q.rd_slot;

    // R8: a stall only begins from a control write aimed at the last slot
    p_stall_from_last_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(reg_we && reg_sel == SEL_CTRL
                                   && reg_wdata[CTRL_WR_BIT] && (&s_q.addr[GROUP_W-1:0])));
    // R4: a stall needs the key sequence armed
    p_stall_needs_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(armed));
    // R3: a stall needs write enable already set
    p_stall_needs_wren_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(s_q.wren));
    // R9: no stall before the lockout has expired
    p_stall_after_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(lock_done));
    // R5: the discarded slot always follows a pending read cycle
    p_discard_after_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_discard) |-> $past(s_q.rd_pend));
    // R12: an address write during the discarded slot changes nothing
    p_discard_ignores_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_discard && reg_we && reg_sel == SEL_ADR_LO) |=> $stable(s_q.addr));
endmodule

// File: tb/pgm_store_ctrl_tb.sv
module pgm_store_ctrl_tb_top;
    import pgm_pkg::*;

    localparam int PROG = 6;
    localparam int LOCK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cpu_stall;
    logic       slot_discard;

    always #5 clk = ~clk;

    pgm_store_ctrl #(
        .PROG_CYCLES    (PROG),
        .LOCKOUT_CYCLES (LOCK)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cpu_stall    (cpu_stall),
        .slot_discard (slot_discard)
    );

    typedef struct {
        int         kind;   // 0 reg_rdata, 1 cpu_stall, 2 slot_discard
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    logic  wren_v = 1'b0;

    // monitor: pop expected items and compare with the outputs
    always @(sample_ev) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {7'b0, cpu_stall};
                default: act = {7'b0, slot_discard};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [2:0] sel,
                               input logic [7:0] e, input string tag);
        item_t it;
        reg_sel = sel;
        #1;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic unlock();
        wr(SEL_KEY, KEY_FIRST);
        wr(SEL_KEY, KEY_SECOND);
    endtask

    task automatic set_addr_data(input logic [9:0] a, input logic [13:0] v);
        wr(SEL_ADR_LO, a[7:0]);
        wr(SEL_ADR_HI, {6'b0, a[9:8]});
        wr(SEL_DAT_LO, v[7:0]);
        wr(SEL_DAT_HI, {2'b0, v[13:8]});
    endtask

    // program one word; R7 / R8 checks on the stall behaviour
    task automatic prog_word(input logic [9:0] a, input logic [13:0] v);
        set_addr_data(a, v);
        unlock();
        wr(SEL_CTRL, 8'h06);
        if (a[1:0] == 2'b11) begin
            expect_item(1, SEL_CTRL, 8'h01, "R8 stall raised");
            repeat (PROG - 1) @(negedge clk);
            expect_item(1, SEL_CTRL, 8'h01, "R8 stall still high");
            @(negedge clk);
            expect_item(1, SEL_CTRL, 8'h00, "R8 stall ended");
        end else begin
            expect_item(1, SEL_CTRL, 8'h00, "R7 no stall for buffer slot");
            expect_item(0, SEL_CTRL, 8'h04, "R7 R2 write bit cleared");
        end
    endtask

    task automatic read_word(input logic [9:0] a, input logic [13:0] e, input string tag);
        wr(SEL_ADR_LO, a[7:0]);
        wr(SEL_ADR_HI, {6'b0, a[9:8]});
        wr(SEL_CTRL, {5'b0, wren_v, 1'b0, 1'b1});
        @(negedge clk);
        @(negedge clk);
        expect_item(0, SEL_DAT_LO, e[7:0], tag);
        expect_item(0, SEL_DAT_HI, {2'b0, e[13:8]}, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state: R3 write enable clear, R4 key reads zero
        expect_item(0, SEL_CTRL, 8'h00, "R3 control after reset");
        expect_item(0, SEL_KEY,  8'h00, "R4 key port reads zero");
        expect_item(1, SEL_CTRL, 8'h00, "R8 no stall after reset");
        expect_item(2, SEL_CTRL, 8'h00, "R5 no discard after reset");

        // R9: full sequence inside the lockout is refused
        wren_v = 1'b1;
        wr(SEL_CTRL, 8'h04);
        set_addr_data(10'h003, 14'h0155);
        unlock();
        wr(SEL_CTRL, 8'h06);
        expect_item(1, SEL_CTRL, 8'h00, "R9 no stall during lockout");
        expect_item(0, SEL_CTRL, 8'h04, "R9 write bit not set during lockout");
        repeat (LOCK) @(negedge clk);
        read_word(10'h003, 14'h3FFF, "R9 R10 refused word stays erased");

        // R4: no key sequence
        set_addr_data(10'h013, 14'h0AAA);
        wr(SEL_CTRL, 8'h06);
        expect_item(1, SEL_CTRL, 8'h00, "R4 refused without key");

        // R3: write enable clear
        wren_v = 1'b0;
        wr(SEL_CTRL, 8'h00);
        expect_item(0, SEL_CTRL, 8'h00, "R3 write enable cleared");
        unlock();
        wr(SEL_CTRL, 8'h02);
        expect_item(1, SEL_CTRL, 8'h00, "R3 refused with enable clear");
        wren_v = 1'b1;
        wr(SEL_CTRL, 8'h04);

        // R11: wrong byte, then an interleaved register write
        wr(SEL_KEY, 8'h55); wr(SEL_KEY, 8'h12); wr(SEL_KEY, 8'hAA);
        wr(SEL_CTRL, 8'h06);
        expect_item(1, SEL_CTRL, 8'h00, "R11 wrong key byte");
        unlock();
        wr(SEL_ADR_LO, 8'h13);
        wr(SEL_CTRL, 8'h06);
        expect_item(1, SEL_CTRL, 8'h00, "R11 interleaved write");
        expect_item(0, SEL_KEY, 8'h00, "R4 key still reads zero");

        // R7 R8: first group of a row
        prog_word(10'h040, 14'h0123);
        prog_word(10'h041, 14'h2345);
        prog_word(10'h042, 14'h3456);
        prog_word(10'h043, 14'h0ABC);
        read_word(10'h040, 14'h0123, "R8 word 0");
        read_word(10'h041, 14'h2345, "R8 word 1");
        read_word(10'h042, 14'h3456, "R8 word 2");
        read_word(10'h043, 14'h0ABC, "R8 word 3");
        read_word(10'h013, 14'h3FFF, "R4 refused word untouched");

        // R10: second group does not erase the row
        prog_word(10'h044, 14'h1111);
        prog_word(10'h045, 14'h1112);
        prog_word(10'h046, 14'h1113);
        prog_word(10'h047, 14'h1114);
        read_word(10'h040, 14'h0123, "R10 no erase from later group");
        read_word(10'h045, 14'h1112, "R10 second group programmed");

        // R10: first group again erases the row
        prog_word(10'h040, 14'h2001);
        prog_word(10'h041, 14'h2002);
        prog_word(10'h042, 14'h2003);
        prog_word(10'h043, 14'h2004);
        read_word(10'h045, 14'h3FFF, "R10 row erased");
        read_word(10'h041, 14'h2002, "R10 new group data");

        // R5 R2 R12: read pipeline timing
        wr(SEL_ADR_LO, 8'h42);
        wr(SEL_CTRL, 8'h05);
        expect_item(2, SEL_CTRL, 8'h00, "R5 first slot runs normally");
        wr(SEL_CTRL, 8'h04);
        expect_item(2, SEL_CTRL, 8'h01, "R5 R2 discard slot despite clear");
        expect_item(0, SEL_CTRL, 8'h05, "R2 read bit not cleared by software");
        wr(SEL_ADR_LO, 8'h99);
        expect_item(0, SEL_ADR_LO, 8'h42, "R12 write in discard slot ignored");
        expect_item(0, SEL_DAT_LO, 8'h03, "R5 data low ready");
        expect_item(0, SEL_DAT_HI, 8'h20, "R5 data high ready");
        expect_item(0, SEL_CTRL, 8'h04, "R2 read bit cleared by hardware");
        expect_item(2, SEL_CTRL, 8'h00, "R5 discard over");

        // R6: hold and software overwrite
        wr(SEL_DAT_LO, 8'h5A);
        expect_item(0, SEL_DAT_LO, 8'h5A, "R6 software write to data");
        expect_item(0, SEL_DAT_HI, 8'h20, "R6 data high held");

        // R1: implemented widths
        wr(SEL_ADR_HI, 8'hFF);
        expect_item(0, SEL_ADR_HI, 8'h03, "R1 address high width");
        wr(SEL_DAT_HI, 8'hFF);
        expect_item(0, SEL_DAT_HI, 8'h3F, "R1 data high width");

        // R1 R12: high address group, write during stall ignored
        prog_word(10'h380, 14'h0001);
        prog_word(10'h381, 14'h0002);
        prog_word(10'h382, 14'h0003);
        set_addr_data(10'h383, 14'h3ABC);
        unlock();
        wr(SEL_CTRL, 8'h06);
        wr(SEL_ADR_LO, 8'h00);
        repeat (PROG - 1) @(negedge clk);
        expect_item(1, SEL_CTRL, 8'h00, "R8 stall length");
        expect_item(0, SEL_ADR_LO, 8'h83, "R12 write during stall ignored");
        read_word(10'h383, 14'h3ABC, "R1 high address word");
        read_word(10'h380, 14'h0001, "R1 high group word 0");
        read_word(10'h083, 14'h3FFF, "R1 aliased low address untouched");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule